// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Countdown Arbiter

This block coordinates load-reserved / store-conditional (LR/SC) pairs among a small group of cores. A core's LR on a free cache line claims a reservation and loads a countdown of 64. The countdown drops by one for each instruction that core retires. If the core issues SC on that line while the count is still live, the SC reports success and the reservation is freed. If the count runs out first, the reservation lapses.

A second core that issues LR on a line someone else holds does not cancel that reservation. Instead the second core is stalled. The stall lasts until the holder frees the line, either by SC or by its count running out. The stalled core is then granted the reservation with a fresh count of 64. The wait is therefore bounded by the holder's remaining count.

Each core presents a line index rather than a byte address. The line index is its address with the six offset bits of a 64-byte line removed. All pins are plain per-cycle control signals. There is no streaming data path and no back-pressure: a stalled core is expected to hold its pipeline while its stall output is high.

Top module: `lrsc_arbiter`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first cycle after it, every `core_stall` and `core_sc_ok` bit is 0, no core holds a reservation and all counts are 0.
- R2: An LR on a line that no other core holds is granted at once, so the core's stall stays 0. An SC by that core on the same line then reports success (`core_sc_ok` high on the cycle after the SC) and frees the line.
- R3: An LR from core B on a line held by core A sets B's stall one cycle later and leaves A's reservation intact. A's later SC on that line still succeeds.
- R4: When the holder's SC succeeds, the lowest-numbered core stalled on that line has its stall cleared at the same clock edge. That core now holds the line with a count of 64, and its own SC succeeds.
- R5: Every retire pulse from a holding core lowers its count by one from 64. After 63 retires an SC still succeeds. After 64 retires the reservation has lapsed and an SC reports failure.
- R6: When a holder's count lapses, the lowest-numbered core stalled on that line is unstalled at the same edge and granted the line.
- R7: An SC from a core with no reservation, or on a line other than the one it holds, reports failure and leaves all reservations unchanged.
- R8: With several cores stalled on one line, each release grants only the lowest-numbered of them. The rest stay stalled behind the new holder.
- R9: An LR by a holder on its own line reloads its count to 64. An LR by a holder on another line gives up the old line and claims the new one.
- R10: While a core's stall is high, its LR, SC and retire inputs are ignored. Its SC reports failure and it stays stalled.
- R11: If several cores issue LR in the same cycle on a free line, the lowest-numbered one is granted and the others are stalled.
- R12: Lines are compared by line index (address bits above bit 5). Two cores on different lines never stall each other.
- R13: `core_sc_ok` is high only on the cycle directly after an SC from that core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| core_lr | input | N_CORES | Per-core LR request, one cycle per instruction |
| core_sc | input | N_CORES | Per-core SC request |
| core_retire | input | N_CORES | Per-core instruction-retired pulse |
| core_line | input | N_CORES*LINE_W | Per-core line index of the LR/SC address, core i at bits [i*LINE_W +: LINE_W] |
| core_stall | output | N_CORES | Core is waiting for a reservation held elsewhere |
| core_sc_ok | output | N_CORES | SC issued last cycle succeeded |

## Verification
The bench targets handover timing. It checks that the waiter's stall drops on exactly the edge where the holder's SC lands or where its 64th retire lands. A design off by one in the count would either let the SC after 64 retires succeed or fail the SC after 63. The bench also places two and three contenders on one line, in the same cycle and across cycles. A wrong priority scan would unstall the higher-numbered core, and a design that grants every waiter at once would give two cores the same line. Ignored-input cases drive SC and LR into a stalled core and SC into a non-holder or onto the wrong line. A design that honours these would report a success or drop a live reservation.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  // What a per-core slot does at the next edge
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_HOLD  = 2'd1,
    ACT_GRANT = 2'd2,
    ACT_WAIT  = 2'd3
  } slot_act_e;
endpackage

// File: rtl/lrsc_slot.sv
module lrsc_slot
  import lrsc_pkg::*;
#(
  parameter int LINE_W     = 26,
  parameter int COUNT_INIT = 64,
  localparam int CW        = $clog2(COUNT_INIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lr,
  input  logic              sc,
  input  logic              retire,
  input  logic [LINE_W-1:0] line,
  input  logic              win,
  output logic              held,
  output logic [LINE_W-1:0] held_line,
  output logic              waiting,
  output logic              cand,
  output logic [LINE_W-1:0] cand_line,
  output logic              keep,
  output logic              sc_ok
);
  logic              hv_q, wv_q, ok_q;
  logic [LINE_W-1:0] hl_q, wl_q;
  logic [CW-1:0]     cnt_q;

  logic lr_self, lr_new, sc_hit, expire;
  slot_act_e act;

  // Inputs of a stalled core are ignored entirely
  assign lr_self = !wv_q && lr && hv_q && (hl_q == line);
  assign lr_new  = !wv_q && lr && !lr_self;
  assign sc_hit  = !wv_q && !lr && sc && hv_q && (hl_q == line);
  assign expire  = hv_q && !wv_q && !lr && !sc_hit && retire && (cnt_q == CW'(1));

  assign keep      = hv_q && !lr_new && !sc_hit && !expire;
  assign cand      = wv_q || lr_new;
  assign cand_line = wv_q ? wl_q : line;

  always_comb begin
    if (cand)      act = win ? ACT_GRANT : ACT_WAIT;
    else if (keep) act = ACT_HOLD;
    else           act = ACT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hv_q  <= 1'b0;
      wv_q  <= 1'b0;
      ok_q  <= 1'b0;
      hl_q  <= '0;
      wl_q  <= '0;
      cnt_q <= '0;
    end else begin
      ok_q <= sc_hit;
      unique case (act)
        ACT_GRANT: begin
          hv_q  <= 1'b1;
          hl_q  <= cand_line;
          cnt_q <= CW'(COUNT_INIT);
          wv_q  <= 1'b0;
        end
        ACT_WAIT: begin
          hv_q  <= 1'b0;
          cnt_q <= '0;
          wv_q  <= 1'b1;
          wl_q  <= cand_line;
        end
        ACT_HOLD: begin
          if (lr_self)     cnt_q <= CW'(COUNT_INIT);
          else if (retire) cnt_q <= cnt_q - CW'(1);
        end
        default: begin
          hv_q  <= 1'b0;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign held      = hv_q;
  assign held_line = hl_q;
  assign waiting   = wv_q;
  assign sc_ok     = ok_q;
endmodule

// File: rtl/lrsc_contend.sv
module lrsc_contend #(
  parameter int N_CORES = 4,
  parameter int LINE_W  = 26
) (
  input  logic [N_CORES-1:0]        cand,
  input  logic [N_CORES*LINE_W-1:0] cand_line,
  input  logic [N_CORES-1:0]        keep,
  input  logic [N_CORES*LINE_W-1:0] held_line,
  output logic [N_CORES-1:0]        win
);
  logic [N_CORES-1:0] free;

  // A candidate is free when no surviving holder owns its line
  for (genvar i = 0; i < N_CORES; i++) begin : g_free
    logic blocked;
    always_comb begin
      blocked = 1'b0;
      for (int j = 0; j < N_CORES; j++) begin
        if (j != i && keep[j] &&
            held_line[j*LINE_W +: LINE_W] == cand_line[i*LINE_W +: LINE_W])
          blocked = 1'b1;
      end
    end
    assign free[i] = cand[i] && !blocked;
  end

  // Among free candidates on one line the lowest index wins
  for (genvar i = 0; i < N_CORES; i++) begin : g_win
    logic beaten;
    always_comb begin
      beaten = 1'b0;
      for (int k = 0; k < i; k++) begin
        if (free[k] &&
            cand_line[k*LINE_W +: LINE_W] == cand_line[i*LINE_W +: LINE_W])
          beaten = 1'b1;
      end
    end
    assign win[i] = free[i] && !beaten;
  end
endmodule

// File: rtl/lrsc_arbiter.sv
module lrsc_arbiter #(
  parameter int N_CORES    = 4,
  parameter int LINE_W     = 26,
  parameter int COUNT_INIT = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CORES-1:0]        core_lr,
  input  logic [N_CORES-1:0]        core_sc,
  input  logic [N_CORES-1:0]        core_retire,
  input  logic [N_CORES*LINE_W-1:0] core_line,
  output logic [N_CORES-1:0]        core_stall,
  output logic [N_CORES-1:0]        core_sc_ok
);
  logic [N_CORES-1:0]        held, waiting, cand, keep, win;
  logic [N_CORES*LINE_W-1:0] held_line, cand_line;

  for (genvar i = 0; i < N_CORES; i++) begin : g_slot
    lrsc_slot #(
      .LINE_W    (LINE_W),
      .COUNT_INIT(COUNT_INIT)
    ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .lr       (core_lr[i]),
      .sc       (core_sc[i]),
      .retire   (core_retire[i]),
      .line     (core_line[i*LINE_W +: LINE_W]),
      .win      (win[i]),
      .held     (held[i]),
      .held_line(held_line[i*LINE_W +: LINE_W]),
      .waiting  (waiting[i]),
      .cand     (cand[i]),
      .cand_line(cand_line[i*LINE_W +: LINE_W]),
      .keep     (keep[i]),
      .sc_ok    (core_sc_ok[i])
    );
  end

  lrsc_contend #(
    .N_CORES(N_CORES),
    .LINE_W (LINE_W)
  ) u_contend (
    .cand     (cand),
    .cand_line(cand_line),
    .keep     (keep),
    .held_line(held_line),
    .win      (win)
  );

  assign core_stall = waiting;
endmodule

// File: rtl/lrsc_arbiter_chk.sv
module lrsc_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] core_sc,
  input logic [N-1:0] core_sc_ok,
  input logic [N-1:0] core_stall,
  input logic [N-1:0] held
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (core_stall == '0 && core_sc_ok == '0));

  for (genvar i = 0; i < N; i++) begin : g_core
    // R10
    stall_no_ok_chk: assert property (@(posedge clk) disable iff (rst)
      core_stall[i] |=> !core_sc_ok[i]);
    // R13
    ok_needs_sc_chk: assert property (@(posedge clk) disable iff (rst)
      !core_sc[i] |=> !core_sc_ok[i]);
    // R3
    hold_xor_wait_chk: assert property (@(posedge clk) disable iff (rst)
      !(held[i] && core_stall[i]));
    // R2
    sc_frees_line_chk: assert property (@(posedge clk) disable iff (rst)
      core_sc_ok[i] |-> (!held[i] && $past(held[i])));
  end
endmodule

bind lrsc_arbiter lrsc_arbiter_chk #(.N(N_CORES)) u_chk (.*);

// File: tb/sim_lrsc_arbiter.sv
module sim_lrsc_arbiter;
  localparam int N = 4, LW = 26, INIT = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [N-1:0]    lr = '0, sc = '0, ret = '0;
  logic [N*LW-1:0] line = '0;
  wire  [N-1:0]    stall, ok;

  lrsc_arbiter #(.N_CORES(N), .LINE_W(LW), .COUNT_INIT(INIT)) u0 (
    .clk(clk), .rst(rst), .core_lr(lr), .core_sc(sc), .core_retire(ret),
    .core_line(line), .core_stall(stall), .core_sc_ok(ok));

  int checks = 0, errors = 0;
  string cur = "R1";

  // Behavioural reference
  bit mh[N]; int mg[N]; int mc[N]; bit mw[N]; int mwg[N]; bit mok[N];

  always @(posedge clk) begin : model
    bit rel[N]; bit want[N]; int tgt[N]; bit nok[N]; int g; bit busy;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        mh[i] = 0; mg[i] = 0; mc[i] = 0; mw[i] = 0; mwg[i] = 0; mok[i] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        g = int'(line[i*LW +: LW]);
        rel[i] = 0; want[i] = 0; tgt[i] = 0; nok[i] = 0;
        if (mw[i]) begin want[i] = 1; tgt[i] = mwg[i]; end
        else if (lr[i]) begin
          if (mh[i] && mg[i] == g) mc[i] = INIT;
          else begin rel[i] = mh[i]; want[i] = 1; tgt[i] = g; end
        end else if (sc[i] && mh[i] && mg[i] == g) begin nok[i] = 1; rel[i] = 1; end
        else if (mh[i] && ret[i]) begin
          if (mc[i] == 1) rel[i] = 1; else mc[i] = mc[i] - 1;
        end
      end
      for (int i = 0; i < N; i++) if (rel[i]) begin mh[i] = 0; mc[i] = 0; end
      for (int i = 0; i < N; i++) if (want[i]) begin
        busy = 0;
        for (int j = 0; j < N; j++) if (mh[j] && mg[j] == tgt[i]) busy = 1;
        if (busy) begin mw[i] = 1; mwg[i] = tgt[i]; end
        else begin mh[i] = 1; mg[i] = tgt[i]; mc[i] = INIT; mw[i] = 0; end
      end
      for (int i = 0; i < N; i++) mok[i] = nok[i];
    end
  end

  always @(negedge clk) if (!rst) begin
    for (int i = 0; i < N; i++) begin
      checks++;
      if (stall[i] !== mw[i]) begin
        errors++;
        $display("FAIL %s model stall core %0d actual %0b expected %0b", cur, i, stall[i], mw[i]);
      end
      checks++;
      if (ok[i] !== mok[i]) begin
        errors++;
        $display("FAIL %s model sc_ok core %0d actual %0b expected %0b", cur, i, ok[i], mok[i]);
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic set_op(int c, bit l, bit s, bit r, logic [31:0] a);
    lr[c] = l; sc[c] = s; ret[c] = r;
    line[c*LW +: LW] = a[31:6];
  endtask

  task automatic tick();
    @(negedge clk);
    lr = '0; sc = '0; ret = '0;
  endtask

  task automatic retires(int c, int n);
    for (int k = 0; k < n; k++) begin set_op(c, 0, 0, 1, 32'h0); tick(); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 stall after reset", stall[0] | stall[1] | stall[2] | stall[3], 1'b0);
    chk("R1 sc_ok after reset", |ok, 1'b0);
    set_op(0, 0, 1, 0, 32'h0); tick();
    chk("R1 SC with nothing reserved", ok[0], 1'b0);

    cur = "R2/R12";
    set_op(0, 1, 0, 0, 32'h1000); tick();
    chk("R2 free LR no stall", stall[0], 1'b0);
    set_op(1, 1, 0, 0, 32'h1040); tick();
    chk("R12 other line no stall", stall[1], 1'b0);
    set_op(0, 0, 1, 0, 32'h1000); tick();
    chk("R2 holder SC ok", ok[0], 1'b1);
    set_op(1, 0, 1, 0, 32'h1040); tick();
    chk("R12 second line SC ok", ok[1], 1'b1);

    cur = "R3/R4/R10";
    set_op(0, 1, 0, 0, 32'h2000); tick();
    set_op(1, 1, 0, 0, 32'h2030); tick();
    chk("R3 conflicting LR stalls", stall[1], 1'b1);
    tick();
    chk("R3 stall holds", stall[1], 1'b1);
    set_op(1, 0, 1, 0, 32'h2000); tick();
    chk("R10 stalled SC fails", ok[1], 1'b0);
    set_op(1, 1, 0, 0, 32'h2040); tick();
    chk("R10 stalled LR ignored", stall[1], 1'b1);
    set_op(0, 0, 1, 0, 32'h2010); tick();
    chk("R3 holder SC ok despite waiter", ok[0], 1'b1);
    chk("R4 waiter unstalled same edge", stall[1], 1'b0);
    set_op(1, 0, 1, 0, 32'h2000); tick();
    chk("R4 waiter SC ok", ok[1], 1'b1);

    cur = "R5";
    set_op(2, 1, 0, 0, 32'h3000); tick();
    retires(2, 63);
    set_op(2, 0, 1, 0, 32'h3000); tick();
    chk("R5 SC after 63 retires ok", ok[2], 1'b1);
    set_op(2, 1, 0, 0, 32'h3000); tick();
    retires(2, 64);
    set_op(2, 0, 1, 0, 32'h3000); tick();
    chk("R5 SC after 64 retires fails", ok[2], 1'b0);

    cur = "R6";
    set_op(2, 1, 0, 0, 32'h4000); tick();
    set_op(3, 1, 0, 0, 32'h4000); tick();
    chk("R6 waiter stalled", stall[3], 1'b1);
    retires(2, 63);
    chk("R6 waiter still stalled at count 1", stall[3], 1'b1);
    retires(2, 1);
    chk("R6 waiter unstalled on expiry", stall[3], 1'b0);
    set_op(2, 0, 1, 0, 32'h4000); tick();
    chk("R6 expired holder SC fails", ok[2], 1'b0);
    set_op(3, 0, 1, 0, 32'h4000); tick();
    chk("R6 new holder SC ok", ok[3], 1'b1);

    cur = "R8";
    set_op(1, 1, 0, 0, 32'h5000); tick();
    set_op(3, 1, 0, 0, 32'h5008); set_op(2, 1, 0, 0, 32'h5008); tick();
    chk("R8 core2 stalled", stall[2], 1'b1);
    chk("R8 core3 stalled", stall[3], 1'b1);
    set_op(1, 0, 1, 0, 32'h5000); tick();
    chk("R8 lowest waiter granted", stall[2], 1'b0);
    chk("R8 higher waiter stays", stall[3], 1'b1);
    set_op(2, 0, 1, 0, 32'h5000); tick();
    chk("R8 second holder SC ok", ok[2], 1'b1);
    chk("R8 last waiter granted", stall[3], 1'b0);
    set_op(3, 0, 1, 0, 32'h5000); tick();
    chk("R8 last SC ok", ok[3], 1'b1);

    cur = "R11";
    set_op(1, 1, 0, 0, 32'h6000); set_op(0, 1, 0, 0, 32'h6000); tick();
    chk("R11 lowest granted", stall[0], 1'b0);
    chk("R11 other stalled", stall[1], 1'b1);
    set_op(0, 0, 1, 0, 32'h6000); tick();
    chk("R11 winner SC ok", ok[0], 1'b1);
    set_op(1, 0, 1, 0, 32'h6000); tick();
    chk("R11 loser later SC ok", ok[1], 1'b1);

    cur = "R9";
    set_op(0, 1, 0, 0, 32'h7000); tick();
    retires(0, 60);
    set_op(0, 1, 0, 0, 32'h7000); tick();
    retires(0, 63);
    set_op(0, 0, 1, 0, 32'h7000); tick();
    chk("R9 reload extends window", ok[0], 1'b1);

    cur = "R7";
    set_op(2, 1, 0, 0, 32'h8000); tick();
    set_op(3, 0, 1, 0, 32'h8000); tick();
    chk("R7 non-holder SC fails", ok[3], 1'b0);
    set_op(2, 0, 1, 0, 32'h8040); tick();
    chk("R7 wrong line SC fails", ok[2], 1'b0);
    set_op(2, 0, 1, 0, 32'h8000); tick();
    chk("R7 reservation kept after failed SCs", ok[2], 1'b1);

    tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule